// File: doc/BRIEF.md
# Integer Add, Subtract and Compare Unit

This is a purely combinational 64-bit integer arithmetic stage for a processor execute pipeline. Two 64-bit operands and a 7-bit function code enter it. It returns a 64-bit result, a flag that asks for an integer-overflow trap, and a flag that marks an unrecognised function code. Selecting a register or a literal for the second operand happens upstream. Writing the result back and taking the trap happen downstream.

The function code selects one of four operation groups:

- **Add/subtract.** Each operation works on either a longword (32 bits) or a quadword (64 bits). The first operand may be pre-scaled by 4 or by 8. Some codes are trapping variants that check for signed overflow.
- **Compare.** Five compares each return a single-bit truth value.
- **Byte compare.** Eight byte lanes are compared in parallel, unsigned. The eight lane outcomes are packed into the low byte of the result.
- **Illegal.** Any other code returns zero and raises the illegal flag.

Top module: `int_arith_unit`

## Requirements
- R1: Addition codes: 0x00 is longword add and 0x20 is quad add. The quad add result is (A + B) mod 2^64.
- R2: Subtraction codes: 0x09 is longword subtract and 0x29 is quad subtract. The quad subtract result is (A - B) mod 2^64.
- R3: Scaled codes shift A left before the operation and never scale B. Shift by 2 (x4): add 0x02 (long) and 0x22 (quad), subtract 0x0b (long) and 0x2b (quad). Shift by 3 (x8): add 0x12 (long) and 0x32 (quad), subtract 0x1b (long) and 0x3b (quad).
- R4: Every longword code (0x00, 0x40, 0x02, 0x12, 0x09, 0x49, 0x0b, 0x1b) works only on bits 31:0. Bits 63:32 of the result copy bit 31, and the upper bits of A and B have no effect.
- R5: Trapping adds are 0x40 (long, sign bit 31) and 0x60 (quad, sign bit 63). The overflow flag is set exactly when A and B have equal sign bits and the result sign differs from A's sign. The wrapped result is still output.
- R6: Trapping subtracts are 0x49 (long, sign bit 31) and 0x69 (quad, sign bit 63). The overflow flag is set exactly when the sign bits of A and B differ and the result sign differs from A's sign. The wrapped result is still output.
- R7: Only the four codes 0x40, 0x60, 0x49 and 0x69 can raise the overflow flag.
- R8: Each compare returns 0 or 1. The codes are 0x2d equal, 0x6d signed less-or-equal, 0x4d signed less-than, 0x3d unsigned less-or-equal and 0x1d unsigned less-than.
- R9: Code 0x0f sets result bit i (i = 0..7) when byte i of A (bits 8i+7:8i) is unsigned greater than or equal to byte i of B. Bits 63:8 of the result are zero.
- R10: Every code not listed in R1 to R9 raises the illegal flag, outputs a zero result and leaves the overflow flag low. Listed codes keep the illegal flag low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 64 | First operand |
| b_i | input | 64 | Second operand |
| fn_i | input | 7 | Function code |
| result_o | output | 64 | Operation result |
| ovf_o | output | 1 | Signed-overflow trap request |
| illegal_o | output | 1 | Unrecognised function code |

## Verification
Two functions can act on the same operation: the overflow trap and the longword sign extension. A trapping longword add or subtract that overflows must return a wrapped 32-bit value extended from bit 31 and must also raise the flag. The bench provokes this in three ways:

- 0x40 with 0x7FFFFFFF + 1.
- 0x49 with 0x80000000 - 1.
- 0x49 with 0 - 0x80000000.

In each case it checks both the full 64-bit result and the flag in the same sample. Quadword cases whose operand signs differ or match confirm that the overflow rule is driven by the operation and not by the result alone.

// File: rtl/int_arith_pkg.sv
package int_arith_pkg;

    localparam int unsigned FN_W = 7;

    typedef enum logic [1:0] {
        KIND_ARITH,
        KIND_CMP,
        KIND_BYTES,
        KIND_BAD
    } kind_e;

    typedef enum logic [2:0] {
        CMP_EQ,
        CMP_SLE,
        CMP_SLT,
        CMP_ULE,
        CMP_ULT
    } cmp_e;

    typedef struct packed {
        kind_e      kind;
        logic       sub;
        logic       longw;
        logic [1:0] shamt;
        logic       trap;
        cmp_e       cmp;
    } ctl_t;

    // add family
    localparam logic [FN_W-1:0] FN_ADD_L    = 7'h00;
    localparam logic [FN_W-1:0] FN_ADD_LV   = 7'h40;
    localparam logic [FN_W-1:0] FN_ADD_L4   = 7'h02;
    localparam logic [FN_W-1:0] FN_ADD_L8   = 7'h12;
    localparam logic [FN_W-1:0] FN_ADD_Q    = 7'h20;
    localparam logic [FN_W-1:0] FN_ADD_QV   = 7'h60;
    localparam logic [FN_W-1:0] FN_ADD_Q4   = 7'h22;
    localparam logic [FN_W-1:0] FN_ADD_Q8   = 7'h32;
    // subtract family
    localparam logic [FN_W-1:0] FN_SUB_L    = 7'h09;
    localparam logic [FN_W-1:0] FN_SUB_LV   = 7'h49;
    localparam logic [FN_W-1:0] FN_SUB_L4   = 7'h0b;
    localparam logic [FN_W-1:0] FN_SUB_L8   = 7'h1b;
    localparam logic [FN_W-1:0] FN_SUB_Q    = 7'h29;
    localparam logic [FN_W-1:0] FN_SUB_QV   = 7'h69;
    localparam logic [FN_W-1:0] FN_SUB_Q4   = 7'h2b;
    localparam logic [FN_W-1:0] FN_SUB_Q8   = 7'h3b;
    // compares
    localparam logic [FN_W-1:0] FN_CMP_EQ   = 7'h2d;
    localparam logic [FN_W-1:0] FN_CMP_SLE  = 7'h6d;
    localparam logic [FN_W-1:0] FN_CMP_SLT  = 7'h4d;
    localparam logic [FN_W-1:0] FN_CMP_ULE  = 7'h3d;
    localparam logic [FN_W-1:0] FN_CMP_ULT  = 7'h1d;
    localparam logic [FN_W-1:0] FN_BYTE_GE  = 7'h0f;

endpackage

// File: rtl/int_arith_decode.sv
module int_arith_decode
    import int_arith_pkg::*;
(
    input  logic [FN_W-1:0] fn_i,
    output ctl_t            ctl_o
);

    always_comb begin
        ctl_o       = '0;
        ctl_o.kind  = KIND_ARITH;
        ctl_o.cmp   = CMP_EQ;
        unique case (fn_i)
            FN_ADD_L:   ctl_o.longw = 1'b1;
            FN_ADD_LV:  begin ctl_o.longw = 1'b1; ctl_o.trap = 1'b1; end
            FN_ADD_L4:  begin ctl_o.longw = 1'b1; ctl_o.shamt = 2'd2; end
            FN_ADD_L8:  begin ctl_o.longw = 1'b1; ctl_o.shamt = 2'd3; end
            FN_ADD_Q:   ctl_o.longw = 1'b0;
            FN_ADD_QV:  ctl_o.trap  = 1'b1;
            FN_ADD_Q4:  ctl_o.shamt = 2'd2;
            FN_ADD_Q8:  ctl_o.shamt = 2'd3;
            FN_SUB_L:   begin ctl_o.sub = 1'b1; ctl_o.longw = 1'b1; end
            FN_SUB_LV:  begin ctl_o.sub = 1'b1; ctl_o.longw = 1'b1; ctl_o.trap = 1'b1; end
            FN_SUB_L4:  begin ctl_o.sub = 1'b1; ctl_o.longw = 1'b1; ctl_o.shamt = 2'd2; end
            FN_SUB_L8:  begin ctl_o.sub = 1'b1; ctl_o.longw = 1'b1; ctl_o.shamt = 2'd3; end
            FN_SUB_Q:   ctl_o.sub = 1'b1;
            FN_SUB_QV:  begin ctl_o.sub = 1'b1; ctl_o.trap = 1'b1; end
            FN_SUB_Q4:  begin ctl_o.sub = 1'b1; ctl_o.shamt = 2'd2; end
            FN_SUB_Q8:  begin ctl_o.sub = 1'b1; ctl_o.shamt = 2'd3; end
            FN_CMP_EQ:  begin ctl_o.kind = KIND_CMP; ctl_o.cmp = CMP_EQ;  end
            FN_CMP_SLE: begin ctl_o.kind = KIND_CMP; ctl_o.cmp = CMP_SLE; end
            FN_CMP_SLT: begin ctl_o.kind = KIND_CMP; ctl_o.cmp = CMP_SLT; end
            FN_CMP_ULE: begin ctl_o.kind = KIND_CMP; ctl_o.cmp = CMP_ULE; end
            FN_CMP_ULT: begin ctl_o.kind = KIND_CMP; ctl_o.cmp = CMP_ULT; end
            FN_BYTE_GE: ctl_o.kind = KIND_BYTES;
            default:    ctl_o.kind = KIND_BAD;
        endcase
    end

endmodule

// File: rtl/int_arith_addsub.sv
module int_arith_addsub #(
    parameter int unsigned DATA_W = 64,
    parameter int unsigned LONG_W = 32
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              sub_i,
    input  logic              longw_i,
    input  logic [1:0]        shamt_i,
    input  logic              trap_i,
    output logic [DATA_W-1:0] result_o,
    output logic              ovf_o
);

    localparam int unsigned EXT_W = DATA_W - LONG_W;

    logic [DATA_W-1:0] a_scaled;
    logic [DATA_W-1:0] raw;
    logic              sgn_a;
    logic              sgn_b;
    logic              sgn_r;
    logic              wrapped;

    always_comb begin
        a_scaled = a_i << shamt_i;
        raw      = sub_i ? (a_scaled - b_i) : (a_scaled + b_i);
        if (longw_i) begin
            result_o = {{EXT_W{raw[LONG_W-1]}}, raw[LONG_W-1:0]};
            sgn_a    = a_scaled[LONG_W-1];
            sgn_b    = b_i[LONG_W-1];
            sgn_r    = raw[LONG_W-1];
        end else begin
            result_o = raw;
            sgn_a    = a_scaled[DATA_W-1];
            sgn_b    = b_i[DATA_W-1];
            sgn_r    = raw[DATA_W-1];
        end
        if (sub_i) begin
            wrapped = (sgn_a != sgn_b) && (sgn_r != sgn_a);
        end else begin
            wrapped = (sgn_a == sgn_b) && (sgn_r != sgn_a);
        end
        ovf_o = trap_i & wrapped;
    end

endmodule

// File: rtl/int_arith_compare.sv
module int_arith_compare
    import int_arith_pkg::*;
#(
    parameter int unsigned DATA_W = 64
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  cmp_e              cmp_i,
    output logic [DATA_W-1:0] result_o
);

    logic hit;

    always_comb begin
        unique case (cmp_i)
            CMP_EQ:  hit = (a_i == b_i);
            CMP_SLE: hit = ($signed(a_i) <= $signed(b_i));
            CMP_SLT: hit = ($signed(a_i) <  $signed(b_i));
            CMP_ULE: hit = (a_i <= b_i);
            CMP_ULT: hit = (a_i <  b_i);
            default: hit = 1'b0;
        endcase
        result_o = {{(DATA_W-1){1'b0}}, hit};
    end

endmodule

// File: rtl/int_arith_bytes.sv
module int_arith_bytes #(
    parameter int unsigned DATA_W = 64,
    parameter int unsigned LANE_W = 8
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic [DATA_W-1:0] result_o
);

    localparam int unsigned LANES = DATA_W / LANE_W;

    logic [LANES-1:0] ge;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign ge[g] = (a_i[g*LANE_W +: LANE_W] >= b_i[g*LANE_W +: LANE_W]);
    end

    assign result_o = {{(DATA_W-LANES){1'b0}}, ge};

endmodule

// File: rtl/int_arith_unit.sv
module int_arith_unit
    import int_arith_pkg::*;
#(
    parameter int unsigned DATA_W = 64,
    parameter int unsigned LONG_W = 32,
    parameter int unsigned LANE_W = 8
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic [FN_W-1:0]   fn_i,
    output logic [DATA_W-1:0] result_o,
    output logic              ovf_o,
    output logic              illegal_o
);

    ctl_t              ctl;
    logic [DATA_W-1:0] arith_res;
    logic              arith_ovf;
    logic [DATA_W-1:0] cmp_res;
    logic [DATA_W-1:0] byte_res;

    int_arith_decode u_dec (
        .fn_i  (fn_i),
        .ctl_o (ctl)
    );

    int_arith_addsub #(.DATA_W(DATA_W), .LONG_W(LONG_W)) u_addsub (
        .a_i      (a_i),
        .b_i      (b_i),
        .sub_i    (ctl.sub),
        .longw_i  (ctl.longw),
        .shamt_i  (ctl.shamt),
        .trap_i   (ctl.trap),
        .result_o (arith_res),
        .ovf_o    (arith_ovf)
    );

    int_arith_compare #(.DATA_W(DATA_W)) u_cmp (
        .a_i      (a_i),
        .b_i      (b_i),
        .cmp_i    (ctl.cmp),
        .result_o (cmp_res)
    );

    int_arith_bytes #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_bytes (
        .a_i      (a_i),
        .b_i      (b_i),
        .result_o (byte_res)
    );

    always_comb begin
        result_o  = '0;
        ovf_o     = 1'b0;
        illegal_o = 1'b0;
        unique case (ctl.kind)
            KIND_ARITH: begin
                result_o = arith_res;
                ovf_o    = arith_ovf;
            end
            KIND_CMP:   result_o  = cmp_res;
            KIND_BYTES: result_o  = byte_res;
            default:    illegal_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/int_arith_unit_chk.sv
module int_arith_unit_chk #(
    parameter int unsigned DATA_W = 64
) (
    input logic [DATA_W-1:0] a_i,
    input logic [DATA_W-1:0] b_i,
    input logic [6:0]        fn_i,
    input logic [DATA_W-1:0] result_o,
    input logic              ovf_o,
    input logic              illegal_o
);

    logic is_trap;
    logic is_cmp;
    logic is_long;
    logic is_known;

    always_comb begin
        is_trap  = fn_i inside {7'h40, 7'h60, 7'h49, 7'h69};
        is_cmp   = fn_i inside {7'h2d, 7'h6d, 7'h4d, 7'h3d, 7'h1d};
        is_long  = fn_i inside {7'h00, 7'h40, 7'h02, 7'h12, 7'h09, 7'h49, 7'h0b, 7'h1b};
        is_known = is_long || is_cmp || (fn_i == 7'h0f) ||
                   (fn_i inside {7'h20, 7'h60, 7'h22, 7'h32, 7'h29, 7'h69, 7'h2b, 7'h3b});
    end

    always @* begin
        // R1: quad add equals modular sum
        p_quad_add_r1: assert (!(fn_i == 7'h20) || result_o == a_i + b_i);
        // R4: longword results are sign extended from bit 31
        p_sext_long_r4: assert (!is_long || result_o[DATA_W-1:32] == {(DATA_W-32){result_o[31]}});
        // R5: add of operands with different signs never overflows
        p_add_mixed_r5: assert (!(fn_i == 7'h60 && a_i[DATA_W-1] != b_i[DATA_W-1]) || !ovf_o);
        // R6: subtract of operands with equal signs never overflows
        p_sub_same_r6: assert (!(fn_i == 7'h69 && a_i[DATA_W-1] == b_i[DATA_W-1]) || !ovf_o);
        // R7: overflow only from trapping codes
        p_no_overflow_r7: assert (!ovf_o || is_trap);
        // R8: compares yield a single bit
        p_bool_cmp_r8: assert (!is_cmp || result_o[DATA_W-1:1] == '0);
        // R9: byte compare leaves upper bits clear
        p_lane_pack_r9: assert (!(fn_i == 7'h0f) || result_o[DATA_W-1:8] == '0);
        // R10: illegal flag tracks the code list, with zero result
        p_bad_code_r10: assert (illegal_o == !is_known);
        p_bad_zero_r10: assert (!illegal_o || (result_o == '0 && !ovf_o));
    end

endmodule

bind int_arith_unit int_arith_unit_chk #(.DATA_W(DATA_W)) u_chk (
    .a_i       (a_i),
    .b_i       (b_i),
    .fn_i      (fn_i),
    .result_o  (result_o),
    .ovf_o     (ovf_o),
    .illegal_o (illegal_o)
);

// File: tb/int_arith_unit_test.sv
module int_arith_unit_test;

    typedef struct packed {
        logic [6:0]  fn;
        logic [63:0] a;
        logic [63:0] b;
        logic [63:0] res;
        logic        ovf;
        logic        bad;
        logic [3:0]  req;
    } vec_t;

    localparam logic [63:0] MAXP = 64'h7FFF_FFFF_FFFF_FFFF;
    localparam logic [63:0] MINN = 64'h8000_0000_0000_0000;
    localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;
    localparam int NVEC = 41;

    localparam vec_t VECS [NVEC] = '{
        '{7'h00, 64'd5, 64'd3, 64'd8, 1'b0, 1'b0, 4'd1},                                   // R1
        '{7'h20, 64'h1_0000_0000, 64'hFFFF_FFFF, 64'h1_FFFF_FFFF, 1'b0, 1'b0, 4'd1},        // R1
        '{7'h20, ONES, 64'd2, 64'd1, 1'b0, 1'b0, 4'd1},                                     // R1
        '{7'h29, 64'd10, 64'd20, 64'hFFFF_FFFF_FFFF_FFF6, 1'b0, 1'b0, 4'd2},                // R2
        '{7'h29, 64'd20, 64'd10, 64'd10, 1'b0, 1'b0, 4'd2},                                 // R2
        '{7'h09, 64'h1_0000_0000, 64'd1, ONES, 1'b0, 1'b0, 4'd2},                           // R2
        '{7'h02, 64'd3, 64'd1, 64'd13, 1'b0, 1'b0, 4'd3},                                   // R3
        '{7'h12, 64'd3, 64'd1, 64'd25, 1'b0, 1'b0, 4'd3},                                   // R3
        '{7'h22, 64'h4000_0000_0000_0001, 64'd0, 64'd4, 1'b0, 1'b0, 4'd3},                  // R3
        '{7'h32, 64'd2, 64'h10, 64'h20, 1'b0, 1'b0, 4'd3},                                  // R3
        '{7'h0b, 64'd5, 64'd1, 64'd19, 1'b0, 1'b0, 4'd3},                                   // R3
        '{7'h1b, 64'd1, 64'd9, ONES, 1'b0, 1'b0, 4'd3},                                     // R3
        '{7'h2b, 64'd1, 64'd4, 64'd0, 1'b0, 1'b0, 4'd3},                                    // R3
        '{7'h3b, 64'd4, 64'd1, 64'h1F, 1'b0, 1'b0, 4'd3},                                   // R3
        '{7'h00, 64'h7FFF_FFFF, 64'd1, 64'hFFFF_FFFF_8000_0000, 1'b0, 1'b0, 4'd4},          // R4
        '{7'h00, 64'hAAAA_AAAA_0000_0001, 64'h5555_5555_0000_0002, 64'd3, 1'b0, 1'b0, 4'd4},// R4
        '{7'h40, 64'h7FFF_FFFF, 64'd1, 64'hFFFF_FFFF_8000_0000, 1'b1, 1'b0, 4'd5},          // R5
        '{7'h40, 64'hFFFF_FFFF, 64'd1, 64'd0, 1'b0, 1'b0, 4'd5},                            // R5
        '{7'h60, MAXP, 64'd1, MINN, 1'b1, 1'b0, 4'd5},                                      // R5
        '{7'h60, MINN, MINN, 64'd0, 1'b1, 1'b0, 4'd5},                                      // R5
        '{7'h60, MAXP, MINN, ONES, 1'b0, 1'b0, 4'd5},                                       // R5
        '{7'h69, MINN, 64'd1, MAXP, 1'b1, 1'b0, 4'd6},                                      // R6
        '{7'h69, MINN, MINN, 64'd0, 1'b0, 1'b0, 4'd6},                                      // R6
        '{7'h49, 64'h8000_0000, 64'd1, 64'h7FFF_FFFF, 1'b1, 1'b0, 4'd6},                    // R6
        '{7'h49, 64'd0, 64'h8000_0000, 64'hFFFF_FFFF_8000_0000, 1'b1, 1'b0, 4'd6},          // R6
        '{7'h20, MAXP, 64'd1, MINN, 1'b0, 1'b0, 4'd7},                                      // R7
        '{7'h29, MINN, 64'd1, MAXP, 1'b0, 1'b0, 4'd7},                                      // R7
        '{7'h2d, 64'd5, 64'd5, 64'd1, 1'b0, 1'b0, 4'd8},                                    // R8
        '{7'h2d, 64'd5, 64'd6, 64'd0, 1'b0, 1'b0, 4'd8},                                    // R8
        '{7'h4d, ONES, 64'd0, 64'd1, 1'b0, 1'b0, 4'd8},                                     // R8
        '{7'h1d, ONES, 64'd0, 64'd0, 1'b0, 1'b0, 4'd8},                                     // R8
        '{7'h1d, 64'd0, ONES, 64'd1, 1'b0, 1'b0, 4'd8},                                     // R8
        '{7'h6d, MINN, MINN, 64'd1, 1'b0, 1'b0, 4'd8},                                      // R8
        '{7'h6d, 64'd0, MINN, 64'd0, 1'b0, 1'b0, 4'd8},                                     // R8
        '{7'h3d, ONES, ONES, 64'd1, 1'b0, 1'b0, 4'd8},                                      // R8
        '{7'h3d, 64'd1, 64'd0, 64'd0, 1'b0, 1'b0, 4'd8},                                    // R8
        '{7'h0f, 64'h00FF_0080_7F01_0203, 64'h0100_FF7F_7F02_0103, 64'h5B, 1'b0, 1'b0, 4'd9},// R9
        '{7'h0f, 64'd0, 64'd0, 64'hFF, 1'b0, 1'b0, 4'd9},                                   // R9
        '{7'h0f, 64'd0, ONES, 64'd0, 1'b0, 1'b0, 4'd9},                                     // R9
        '{7'h01, 64'd5, 64'd3, 64'd0, 1'b0, 1'b1, 4'd10},                                   // R10
        '{7'h7f, MAXP, 64'd1, 64'd0, 1'b0, 1'b1, 4'd10}                                     // R10
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] a;
    logic [63:0] b;
    logic [6:0]  fn;
    logic [63:0] result;
    logic        ovf;
    logic        illegal;
    int          n_checks = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    int_arith_unit uut (
        .a_i       (a),
        .b_i       (b),
        .fn_i      (fn),
        .result_o  (result),
        .ovf_o     (ovf),
        .illegal_o (illegal)
    );

    task automatic check(input int req, input string what, input logic [63:0] got, input logic [63:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s fn=%h: got %h expected %h", req, what, fn, got, exp);
        end
    endtask

    task automatic apply(input logic [6:0] f, input logic [63:0] x, input logic [63:0] y);
        @(posedge clk);
        #2;
        fn = f;
        a  = x;
        b  = y;
        @(negedge clk);
    endtask

    function automatic bit known_code(input logic [6:0] f);
        return f inside {7'h00, 7'h40, 7'h02, 7'h12, 7'h20, 7'h60, 7'h22, 7'h32,
                         7'h09, 7'h49, 7'h0b, 7'h1b, 7'h29, 7'h69, 7'h2b, 7'h3b,
                         7'h2d, 7'h6d, 7'h4d, 7'h3d, 7'h1d, 7'h0f};
    endfunction

    initial begin
        a  = '0;
        b  = '0;
        fn = '0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        // reset state: zero operands with code 0x00 (R1)
        check(1, "reset result", result, 64'd0);
        check(7, "reset ovf", {63'd0, ovf}, 64'd0);
        check(10, "reset illegal", {63'd0, illegal}, 64'd0);

        for (int i = 0; i < NVEC; i++) begin
            apply(VECS[i].fn, VECS[i].a, VECS[i].b);
            check(int'(VECS[i].req), "result", result, VECS[i].res);
            check(int'(VECS[i].req), "ovf", {63'd0, ovf}, {63'd0, VECS[i].ovf});
            check(int'(VECS[i].req), "illegal", {63'd0, illegal}, {63'd0, VECS[i].bad});
        end

        // R10 / R7 sweep over every code with an overflowing operand pair
        for (int c = 0; c < 128; c++) begin
            apply(7'(c), MAXP, 64'd1);
            check(10, "sweep illegal", {63'd0, illegal}, {63'd0, !known_code(7'(c))});
            if (!(7'(c) inside {7'h40, 7'h60, 7'h49, 7'h69}))
                check(7, "sweep ovf", {63'd0, ovf}, 64'd0);
            if (!known_code(7'(c)))
                check(10, "sweep zero", result, 64'd0);
        end

        // R4 + R5 together: trapping longword overflow keeps sign extension
        apply(7'h40, 64'hFFFF_FFFF_7FFF_FFFF, 64'h1234_5678_0000_0001);
        check(5, "long trap result", result, 64'hFFFF_FFFF_8000_0000);
        check(5, "long trap ovf", {63'd0, ovf}, 64'd1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule